// File: doc/BRIEF.md
# Multiprocessor-Filtering UART Receiver

This block receives asynchronous serial characters from a single line. It samples the line on a one-cycle sample tick that runs at sixteen times the bit rate. It assembles eight data bits, sent least significant bit first, and then an optional parity bit and an optional multiprocessor bit before the stop bit. A received byte is handed out on a valid/ready port. Parity, framing and overrun problems are reported on three sticky flags, which a single clear pulse resets.

On a bus shared by several nodes, the multiprocessor format adds one bit to every frame. This bit marks the frame as an address character. With filtering switched on, the receiver discards every frame whose multiprocessor bit is low. A discarded frame does not raise the valid output and does not change any flag. If the receiver enable goes low, the frame in progress is abandoned, and the held byte and all flags keep their values.

Back-pressure rules for the output port: `rd_valid` stays high and `rd_data` stays stable until a cycle with `rd_ready` high. That handshake clears `rd_valid` at the next edge. The port has no queue behind it. If a new frame is accepted while a byte is still held and no handshake happens in that cycle, the overrun flag is set and the held byte is kept.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset, `rd_valid`, `err_parity`, `err_frame` and `err_overrun` are all 0.
- R2: A frame is a low start bit, then 8 data bits with the least significant bit first, then a parity bit when `cfg_par_en`=1, then a multiprocessor bit when `cfg_mp_fmt`=1, then a stop bit. Each bit lasts 16 sample ticks. The byte of an accepted frame appears on `rd_data` with `rd_valid`=1.
- R3: A start bit begins at a high-to-low change seen on a tick. It is confirmed only if the line is still low at the 8th tick, counting the edge tick as the first. Otherwise the receiver returns to idle and reports nothing.
- R4: While `rd_valid`=1 and `rd_ready`=0, `rd_valid` stays 1 and `rd_data` stays stable. A cycle with both high clears `rd_valid` at the next edge.
- R5: If a frame is accepted while `rd_valid`=1 and `rd_ready`=0, `err_overrun` is set and `rd_data` keeps the earlier byte.
- R6: With `cfg_par_en`=1, `err_parity` is set when the count of ones over the data bits plus the parity bit is odd and `cfg_par_odd`=0 (even parity), or when that count is even and `cfg_par_odd`=1 (odd parity). The byte is still delivered.
- R7: When the stop bit of an accepted frame is sampled low, `err_frame` is set. The byte is still delivered.
- R8: With `cfg_mp_fmt`=1 and `cfg_mp_en`=1, a frame whose multiprocessor bit is 0 is discarded. It does not raise `rd_valid` and does not change any error flag, including `err_overrun` while a byte is held.
- R9: With `cfg_mp_fmt`=0, `cfg_mp_en` has no effect and every frame is accepted. With `cfg_mp_fmt`=1 and `cfg_mp_en`=0, every frame is accepted, whatever its multiprocessor bit.
- R10: While `cfg_rx_en`=0, a frame in progress is aborted and no frame is received. `rd_valid`, `rd_data` and all error flags keep their values.
- R11: Error flags stay set until a one-cycle pulse on `err_clr`. A handshake on the data port does not clear them. A new error in the same cycle as `err_clr` leaves its flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_rx_en | input | 1 | Receiver enable |
| cfg_mp_en | input | 1 | Filtering enable (effective only with cfg_mp_fmt) |
| cfg_mp_fmt | input | 1 | Frames carry a multiprocessor bit |
| cfg_par_en | input | 1 | Frames carry a parity bit |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| err_clr | input | 1 | Clears all error flags |
| rd_valid | output | 1 | A received byte is held |
| rd_ready | input | 1 | Consumer takes the held byte |
| rd_data | output | 8 | Held byte |
| err_parity | output | 1 | Sticky parity error |
| err_frame | output | 1 | Sticky framing error |
| err_overrun | output | 1 | Sticky overrun error |

## Verification
The line passes through a two-stage synchronizer and then waits for the next tick, so each sample lands 30 to 34 clocks into a 64-clock bit when a tick comes every fourth clock. `rd_valid` and the error flags change one clock after the stop-bit sample, which is about half a bit into the stop bit. The bench therefore holds the stop bit for a full bit time and then one idle bit before it reads any flag. A handshake drops `rd_valid` at the next edge. The scoreboard monitor compares the byte at the falling edge inside the handshake cycle, so each handshake is seen exactly once.

// File: rtl/mpurx_pkg.sv
package mpurx_pkg;
  localparam int unsigned MPURX_DW = 8;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_MPB,
    RX_STOP
  } rx_state_e;

  typedef struct packed {
    logic [MPURX_DW-1:0] data;
    logic                par;
    logic                mpb;
    logic                stop;
  } rx_frame_t;
endpackage

// File: rtl/mpurx_sync.sv
module mpurx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sh <= '1;
        else        sh <= din;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sh <= '1;
        else        sh <= {sh[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = sh[STAGES-1];
endmodule

// File: rtl/mpurx_frame.sv
module mpurx_frame
  import mpurx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      line,
  input  logic      rx_en,
  input  logic      par_en,
  input  logic      mp_fmt,
  output logic      frm_done,
  output rx_frame_t frm
);
  localparam int unsigned CW = $clog2(OVS);
  localparam int unsigned IW = $clog2(MPURX_DW);
  localparam logic [CW-1:0] MID  = CW'(OVS/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OVS - 1);
  localparam logic [IW-1:0] LAST_BIT = IW'(MPURX_DW - 1);

  rx_state_e            st;
  logic [CW-1:0]        cnt;
  logic [IW-1:0]        idx;
  logic [MPURX_DW-1:0]  shreg;
  logic                 par_b;
  logic                 mpb_b;
  logic                 line_q;
  logic                 bit_pt;

  // sample point in the middle of a data, parity, mp or stop bit
  assign bit_pt = tick && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= RX_IDLE;
      cnt      <= '0;
      idx      <= '0;
      shreg    <= '0;
      par_b    <= 1'b0;
      mpb_b    <= 1'b0;
      line_q   <= 1'b1;
      frm_done <= 1'b0;
      frm      <= '0;
    end else begin
      frm_done <= 1'b0;
      if (tick) line_q <= line;
      if (!rx_en) begin
        st  <= RX_IDLE;
        cnt <= '0;
      end else if (tick) begin
        unique case (st)
          RX_IDLE: begin
            if (line_q && !line) begin
              st  <= RX_START;
              cnt <= CW'(1);
            end
          end
          RX_START: begin
            if (cnt == MID) begin
              cnt <= '0;
              idx <= '0;
              st  <= line ? RX_IDLE : RX_DATA;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: cnt <= bit_pt ? '0 : cnt + 1'b1;
        endcase

        if (bit_pt) begin
          unique case (st)
            RX_DATA: begin
              shreg <= {line, shreg[MPURX_DW-1:1]};
              if (idx == LAST_BIT)
                st <= par_en ? RX_PAR : (mp_fmt ? RX_MPB : RX_STOP);
              else
                idx <= idx + 1'b1;
            end
            RX_PAR: begin
              par_b <= line;
              st    <= mp_fmt ? RX_MPB : RX_STOP;
            end
            RX_MPB: begin
              mpb_b <= line;
              st    <= RX_STOP;
            end
            RX_STOP: begin
              frm_done <= 1'b1;
              frm      <= '{data: shreg, par: par_b, mpb: mpb_b, stop: line};
              st       <= RX_IDLE;
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/mpurx_status.sv
module mpurx_status
  import mpurx_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frm_done,
  input  rx_frame_t           frm,
  input  logic                mp_en,
  input  logic                mp_fmt,
  input  logic                par_en,
  input  logic                par_odd,
  input  logic                err_clr,
  input  logic                rd_ready,
  output logic                rd_valid,
  output logic [MPURX_DW-1:0] rd_data,
  output logic                err_parity,
  output logic                err_frame,
  output logic                err_overrun
);
  logic accept, take, par_bad, blocked;

  assign accept  = frm_done && !(mp_fmt && mp_en && !frm.mpb);
  assign take    = rd_valid && rd_ready;
  assign par_bad = par_en && ((^{frm.data, frm.par}) != par_odd);
  assign blocked = rd_valid && !take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      err_parity  <= 1'b0;
      err_frame   <= 1'b0;
      err_overrun <= 1'b0;
    end else begin
      if (take) rd_valid <= 1'b0;
      if (accept && !blocked) begin
        rd_data  <= frm.data;
        rd_valid <= 1'b1;
      end
      err_parity  <= (err_parity  && !err_clr) || (accept && par_bad);
      err_frame   <= (err_frame   && !err_clr) || (accept && !frm.stop);
      err_overrun <= (err_overrun && !err_clr) || (accept && blocked);
    end
  end
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
  import mpurx_pkg::*;
#(
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_tick,
  input  logic                rxd,
  input  logic                cfg_rx_en,
  input  logic                cfg_mp_en,
  input  logic                cfg_mp_fmt,
  input  logic                cfg_par_en,
  input  logic                cfg_par_odd,
  input  logic                err_clr,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic [MPURX_DW-1:0] rd_data,
  output logic                err_parity,
  output logic                err_frame,
  output logic                err_overrun
);
  logic      line_s;
  logic      frm_done;
  rx_frame_t frm_q;
  logic      frm_mpb;
  logic      frm_stop;

  assign frm_mpb  = frm_q.mpb;
  assign frm_stop = frm_q.stop;

  mpurx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rxd),
    .dout (line_s)
  );

  mpurx_frame #(.OVS(OVS)) u_frame (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (sample_tick),
    .line    (line_s),
    .rx_en   (cfg_rx_en),
    .par_en  (cfg_par_en),
    .mp_fmt  (cfg_mp_fmt),
    .frm_done(frm_done),
    .frm     (frm_q)
  );

  mpurx_status u_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .frm_done   (frm_done),
    .frm        (frm_q),
    .mp_en      (cfg_mp_en),
    .mp_fmt     (cfg_mp_fmt),
    .par_en     (cfg_par_en),
    .par_odd    (cfg_par_odd),
    .err_clr    (err_clr),
    .rd_ready   (rd_ready),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .err_parity (err_parity),
    .err_frame  (err_frame),
    .err_overrun(err_overrun)
  );
endmodule

// File: rtl/mpurx_chk.sv
module mpurx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_rx_en,
  input logic       cfg_mp_en,
  input logic       cfg_mp_fmt,
  input logic       err_clr,
  input logic       frm_done,
  input logic       frm_mpb,
  input logic       frm_stop,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic       err_parity,
  input logic       err_frame,
  input logic       err_overrun
);
  logic drop;
  assign drop = frm_done && cfg_mp_fmt && cfg_mp_en && !frm_mpb;

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  a_r4_take: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && rd_ready && !frm_done |=> !rd_valid);

  a_r5_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done && !drop && rd_valid && !rd_ready |=> err_overrun && $stable(rd_data));

  a_r7_frame: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done && !drop && !frm_stop |=> err_frame);

  a_r8_drop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    drop && !rd_valid |=> !rd_valid);

  a_r8_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    drop && !err_clr |=> $stable(err_parity) && $stable(err_frame) && $stable(err_overrun));

  a_r10_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rx_en && !$past(cfg_rx_en) && !err_clr && !(rd_valid && rd_ready)
      |=> $stable(rd_valid) && $stable(err_frame) && $stable(err_parity));

  a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_frame || err_parity || err_overrun) && !err_clr
      |=> (err_frame || err_parity || err_overrun));
endmodule

bind mp_uart_rx mpurx_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cfg_rx_en  (cfg_rx_en),
  .cfg_mp_en  (cfg_mp_en),
  .cfg_mp_fmt (cfg_mp_fmt),
  .err_clr    (err_clr),
  .frm_done   (frm_done),
  .frm_mpb    (frm_mpb),
  .frm_stop   (frm_stop),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .rd_data    (rd_data),
  .err_parity (err_parity),
  .err_frame  (err_frame),
  .err_overrun(err_overrun)
);

// File: tb/sim_mp_uart_rx.sv
`timescale 1ns/1ps
module sim_mp_uart_rx;
  localparam int BIT_CLKS = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_tick = 1'b0;
  logic rxd = 1'b1;
  logic cfg_rx_en = 1'b1, cfg_mp_en = 1'b0, cfg_mp_fmt = 1'b0;
  logic cfg_par_en = 1'b0, cfg_par_odd = 1'b0, err_clr = 1'b0;
  logic rd_ready = 1'b1;
  logic rd_valid, err_parity, err_frame, err_overrun;
  logic [7:0] rd_data;

  int n_run = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];

  always #2 clk = ~clk;

  mp_uart_rx u0 (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .rxd(rxd),
    .cfg_rx_en(cfg_rx_en), .cfg_mp_en(cfg_mp_en), .cfg_mp_fmt(cfg_mp_fmt),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .err_clr(err_clr),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .err_parity(err_parity), .err_frame(err_frame), .err_overrun(err_overrun)
  );

  initial begin
    int ph = 0;
    forever begin
      @(negedge clk);
      sample_tick = (ph == 3);
      ph = (ph + 1) % 4;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor: compare each handshaken byte with the queue head
  always @(negedge clk) begin
    if (rst_n && rd_valid && rd_ready) begin
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R2/R8: unexpected byte got %0h expected none", rd_data);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (rd_data !== e) begin
          n_fail++;
          $display("FAIL R2: byte got %0h expected %0h", rd_data, e);
        end
      end
    end
  end

  task automatic send_bit(input logic b);
    rxd = b;
    repeat (BIT_CLKS) @(negedge clk);
  endtask

  function automatic logic par_of(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  // driver: sends one frame; pushes the byte when it is expected to arrive
  task automatic send_frame(input logic [7:0] d, input logic p, input logic m,
                            input logic stop, input logic expect_it);
    if (expect_it) exp_q.push_back(d);
    send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(d[i]);
    if (cfg_par_en) send_bit(p);
    if (cfg_mp_fmt) send_bit(m);
    send_bit(stop);
    send_bit(1'b1);
  endtask

  task automatic pulse_clr();
    err_clr = 1'b1;
    @(negedge clk);
    err_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 valid", rd_valid, 0);
    chk("R1 errors", {err_parity, err_frame, err_overrun}, 0);
    send_bit(1'b1);

    // R2 plain 8N1 frames, several patterns
    send_frame(8'hA5, 0, 0, 1, 1);
    send_frame(8'h00, 0, 0, 1, 1);
    send_frame(8'hFF, 0, 0, 1, 1);
    send_frame(8'h3C, 0, 0, 1, 1);
    chk("R2 clean errors", {err_parity, err_frame, err_overrun}, 0);

    // R3 short low glitch is not a start bit
    rxd = 1'b0;
    repeat (16) @(negedge clk);
    rxd = 1'b1;
    repeat (3*BIT_CLKS) @(negedge clk);
    chk("R3 glitch valid", rd_valid, 0);
    chk("R3 glitch errors", {err_parity, err_frame, err_overrun}, 0);
    send_frame(8'h96, 0, 0, 1, 1);

    // R6 parity even then odd
    cfg_par_en = 1'b1;
    send_frame(8'h37, par_of(8'h37, 0), 0, 1, 1);
    chk("R6 even good", err_parity, 0);
    send_frame(8'h37, ~par_of(8'h37, 0), 0, 1, 1);
    chk("R6 even bad", err_parity, 1);
    pulse_clr();
    chk("R11 clear parity", err_parity, 0);
    cfg_par_odd = 1'b1;
    send_frame(8'h81, par_of(8'h81, 1), 0, 1, 1);
    chk("R6 odd good", err_parity, 0);
    send_frame(8'h81, par_of(8'h81, 0), 0, 1, 1);
    chk("R6 odd bad", err_parity, 1);
    pulse_clr();
    cfg_par_en = 1'b0;
    cfg_par_odd = 1'b0;

    // R7 framing error, sticky through reads (R11)
    send_frame(8'h5A, 0, 0, 0, 1);
    chk("R7 frame err", err_frame, 1);
    send_frame(8'h11, 0, 0, 1, 1);
    chk("R11 sticky after read", err_frame, 1);
    pulse_clr();
    chk("R11 clear frame", err_frame, 0);

    // R4/R5 back-pressure and overrun
    rd_ready = 1'b0;
    send_frame(8'hC3, 0, 0, 1, 1);
    chk("R4 held valid", rd_valid, 1);
    chk("R4 held data", rd_data, 8'hC3);
    chk("R5 no overrun yet", err_overrun, 0);
    send_frame(8'h44, 0, 0, 1, 0);
    chk("R5 overrun set", err_overrun, 1);
    chk("R5 old byte kept", rd_data, 8'hC3);
    rd_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 valid cleared", rd_valid, 0);
    chk("R11 overrun kept after read", err_overrun, 1);
    pulse_clr();

    // R8 filtering
    cfg_mp_fmt = 1'b1;
    cfg_mp_en  = 1'b1;
    send_frame(8'h12, 0, 0, 0, 0);
    chk("R8 dropped no valid", rd_valid, 0);
    chk("R8 dropped no errors", {err_parity, err_frame, err_overrun}, 0);
    send_frame(8'h81, 0, 1, 1, 1);
    chk("R8 address accepted errors", {err_parity, err_frame, err_overrun}, 0);
    rd_ready = 1'b0;
    send_frame(8'h82, 0, 1, 1, 1);
    send_frame(8'h13, 0, 0, 1, 0);
    chk("R8 drop while full no overrun", err_overrun, 0);
    chk("R8 drop while full data", rd_data, 8'h82);
    rd_ready = 1'b1;
    repeat (3) @(negedge clk);

    // R9 filtering off paths
    cfg_mp_en = 1'b0;
    send_frame(8'h24, 0, 0, 1, 1);
    cfg_mp_fmt = 1'b0;
    cfg_mp_en  = 1'b1;
    send_frame(8'h42, 0, 0, 1, 1);
    chk("R9 accepted errors", {err_parity, err_frame, err_overrun}, 0);
    cfg_mp_en = 1'b0;

    // R10 abort mid-frame keeps held byte and flags
    rd_ready = 1'b0;
    send_frame(8'h5A, 0, 0, 0, 1);
    send_bit(1'b0);
    send_bit(1'b1);
    send_bit(1'b0);
    cfg_rx_en = 1'b0;
    for (int i = 0; i < 6; i++) send_bit(1'b0);
    send_bit(1'b0);
    chk("R10 valid kept", rd_valid, 1);
    chk("R10 data kept", rd_data, 8'h5A);
    chk("R10 frame err kept", err_frame, 1);
    chk("R10 no overrun", err_overrun, 0);
    rxd = 1'b1;
    send_bit(1'b1);
    send_frame(8'h77, 0, 0, 1, 0);
    chk("R10 disabled ignores frame", {rd_data, err_overrun}, {8'h5A, 1'b0});
    rd_ready = 1'b1;
    repeat (3) @(negedge clk);
    pulse_clr();
    cfg_rx_en = 1'b1;
    send_bit(1'b1);
    send_frame(8'hE7, 0, 0, 1, 1);
    chk("R10 re-enabled errors", {err_parity, err_frame, err_overrun}, 0);

    repeat (10) @(negedge clk);
    chk("R2 scoreboard drained", exp_q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule